// File: doc/BRIEF.md
# Sample-Synchronous Shift Chain Driver

This block feeds a long chain of serial-in, parallel-out registers. Each register in the chain has an output storage stage that copies the shifted bits to its pins on a rising edge of a shared latch line. Software or an upstream engine loads one frame at a time through a valid/ready handshake. Each frame holds `WORDS` words of `WORD_W` bits for every data lane.

A sample-rate `tick` paces the block. When a tick is accepted, the block first raises the latch for one system cycle. That edge publishes the frame shifted during the previous period, so output updates stay evenly spaced no matter how fast the bit clock runs. On the next cycle the latch drops, and the new frame is serialized onto all lanes. The lanes share one bit clock. The bit clock is the system clock divided by `DIV`. The latch then stays low until the next accepted tick.

If no frame is waiting when a tick arrives, the block shifts the previous frame again. If a tick arrives while the block is still busy, it is dropped. Both events set a sticky underflow flag.

Top module: `sample_chain_driver`

## Requirements
- R1: While `rst_n` is low, `latch`, `sclk`, `sdata` and `underflow` are 0 and `ld_ready` is 1. The frame that is repeated before any load is all zeros.
- R2: A `tick` sampled while the block is idle sets `latch` high for exactly one cycle, starting in the cycle after the sampling edge. `latch` never rises without an accepted tick.
- R3: The shift starts in the cycle after `latch` falls. Each bit lasts `DIV` cycles: `sclk` is low for the first `DIV/2` cycles and high for the last `DIV/2`. When no shift is running, `sclk` is low.
- R4: Lane l, word w comes from `ld_data[(l*WORDS+w)*WORD_W +: WORD_W]`. Word `WORDS-1` goes out first and word 0 goes out last, each MSB first. `sdata` changes only while `sclk` is low, and it holds its value across each rising `sclk` edge.
- R5: Each accepted tick produces exactly `WORDS*WORD_W` rising `sclk` edges. After the last bit, `sclk` and `sdata` return to 0.
- R6: `ld_ready` is high while the one-frame buffer is empty. A cycle with `ld_valid` and `ld_ready` both high stores `ld_data` and drops `ld_ready`. `ld_ready` returns high only after an accepted tick takes that frame.
- R7: An accepted tick that finds the buffer empty still raises `latch`, shifts the previous frame again and sets `underflow`. This holds even if `ld_valid` is high in the same cycle; the frame loaded in that cycle waits for the next tick.
- R8: A `tick` sampled while `latch` is high or a shift is running produces no latch pulse, consumes no buffered frame and sets `underflow`.
- R9: `underflow` stays at 1 until reset, including across later correct frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate pulse, one cycle wide |
| ld_valid | input | 1 | Frame offered on `ld_data` |
| ld_data | input | LANES*WORDS*WORD_W | Frame for all lanes |
| ld_ready | output | 1 | One-frame buffer is empty |
| sclk | output | 1 | Shared bit clock |
| sdata | output | LANES | Serial data, one bit per lane |
| latch | output | 1 | Storage strobe for the chain, rising edge active |
| underflow | output | 1 | Sticky flag for a missing frame or a dropped tick |

## Verification
A wrong bit counter or phase counter shows up on `sclk` or `sdata` in the same cycle it goes wrong, because the bench predicts both pins on every cycle of every shift. A buffer-full flag that is stuck or cleared at the wrong time shows on `ld_ready` at once. It also shows on the data lanes, as a repeated or skipped frame, within one sample period. Errors in tick acceptance show up as an extra or missing latch pulse, or as `underflow` moving in the cycle after the offending tick.

// File: rtl/sample_chain_driver.sv
module sample_chain_driver #(
  parameter int LANES  = 2,
  parameter int WORDS  = 4,
  parameter int WORD_W = 16,
  parameter int DIV    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          ld_valid,
  input  logic [LANES*WORDS*WORD_W-1:0] ld_data,
  output logic                          ld_ready,
  output logic                          sclk,
  output logic [LANES-1:0]              sdata,
  output logic                          latch,
  output logic                          underflow
);
  localparam int FB   = WORDS * WORD_W;
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW   = (FB > 2) ? $clog2(FB) : 1;

  logic [LANES*FB-1:0] pend_q, cur_q;
  logic                full_q, busy_q;
  logic [CW-1:0]       cnt_q;
  logic [BW-1:0]       bit_q;

  wire accept   = tick & ~latch & ~busy_q;
  wire take     = ld_valid & ~full_q;
  wire bit_end  = busy_q & (cnt_q == CW'(DIV - 1));
  wire last_bit = (bit_q == BW'(FB - 1));

  assign ld_ready = ~full_q;
  assign sclk     = busy_q & (cnt_q >= CW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      cur_q     <= '0;
      full_q    <= 1'b0;
      latch     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      latch <= accept;
      if (take) begin
        pend_q <= ld_data;
        full_q <= 1'b1;
      end
      if (accept) begin
        if (full_q) begin
          cur_q  <= pend_q;
          full_q <= 1'b0;
        end else begin
          underflow <= 1'b1;
        end
      end else if (tick) begin
        underflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (latch) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (bit_end) begin
        cnt_q <= '0;
        if (last_bit) busy_q <= 1'b0;
        else          bit_q  <= bit_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [FB-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     sh_q <= '0;
      else if (latch)                 sh_q <= cur_q[l*FB +: FB];
      else if (bit_end && !last_bit)  sh_q <= {sh_q[FB-2:0], 1'b0};
    end
    assign sdata[l] = busy_q & sh_q[FB-1];
  end
endmodule

// File: rtl/sample_chain_driver_chk.sv
module sample_chain_driver_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             sclk,
  input logic [LANES-1:0] sdata,
  input logic             latch,
  input logic             underflow
);
  p_latch_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch);

  p_latch_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> $past(tick));

  p_quiet_in_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (!sclk && sdata == '0));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);

  p_busy_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && latch) |=> (!latch && underflow));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

bind sample_chain_driver sample_chain_driver_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .sclk(sclk), .sdata(sdata), .latch(latch),
  .underflow(underflow)
);

// File: tb/sample_chain_driver_tb_top.sv
module sample_chain_driver_tb_top;
  localparam int LANES = 2, WORDS = 4, WORD_W = 16, DIV = 4;
  localparam int FB = WORDS * WORD_W;
  localparam int FW = LANES * FB;
  localparam int PER = 300;

  logic          clk = 0, rst_n = 0, tick = 0, ld_valid = 0;
  logic [FW-1:0] ld_data = '0;
  logic          ld_ready, sclk, latch, underflow;
  logic [LANES-1:0] sdata;

  int errors = 0, checks = 0, cyc = 0;
  int rises = 0, latch_rises = 0;
  logic prev_sclk = 0, prev_latch = 0;

  bit m_latch, m_busy, m_full, m_uf;
  int m_el;
  logic [FW-1:0] m_pend, m_cur;

  sample_chain_driver #(.LANES(LANES), .WORDS(WORDS), .WORD_W(WORD_W), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .sclk(sclk), .sdata(sdata), .latch(latch), .underflow(underflow));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit o_latch, o_busy, o_full;
    cyc++;
    if (!rst_n) begin
      m_latch = 0; m_busy = 0; m_full = 0; m_uf = 0; m_el = 0;
      m_pend = '0; m_cur = '0;
    end else begin
      o_latch = m_latch; o_busy = m_busy; o_full = m_full;
      m_latch = 0;
      if (o_latch) begin
        m_busy = 1; m_el = 0;
      end else if (o_busy) begin
        m_el++;
        if (m_el == FB * DIV) m_busy = 0;
      end
      if (tick) begin
        if (o_latch || o_busy) m_uf = 1;
        else begin
          m_latch = 1;
          if (o_full) begin m_cur = m_pend; m_full = 0; end
          else m_uf = 1;
        end
      end
      if (ld_valid && !o_full) begin m_pend = ld_data; m_full = 1; end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0; latch_rises = 0; prev_sclk = 0; prev_latch = 0;
    end else begin
      logic [LANES-1:0] e_sd;
      logic e_sclk;
      int k;
      k = m_el / DIV;
      e_sclk = m_busy && ((m_el % DIV) >= DIV / 2);
      for (int l = 0; l < LANES; l++)
        e_sd[l] = m_busy ? m_cur[l*FB + FB-1-k] : 1'b0;
      chk("R2 latch", FW'(latch), FW'(m_latch));
      chk("R3 sclk", FW'(sclk), FW'(e_sclk));
      chk("R4 sdata", FW'(sdata), FW'(e_sd));
      chk("R6 ld_ready", FW'(ld_ready), FW'(!m_full));
      chk("R9 underflow", FW'(underflow), FW'(m_uf));
      if (sclk && !prev_sclk) rises++;
      if (latch && !prev_latch) latch_rises++;
      prev_sclk = sclk; prev_latch = latch;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0; ld_valid = 0;
    wait_n(3);
    chk("R1 latch", FW'(latch), '0);
    chk("R1 sclk", FW'(sclk), '0);
    chk("R1 sdata", FW'(sdata), '0);
    chk("R1 ld_ready", FW'(ld_ready), FW'(1));
    chk("R1 underflow", FW'(underflow), '0);
    rst_n = 1;
  endtask
  task automatic load(input logic [FW-1:0] d);
    @(negedge clk); ld_valid = 1; ld_data = d;
    @(negedge clk); ld_valid = 0;
  endtask
  task automatic pulse(input int len);
    @(negedge clk); tick = 1;
    repeat (len) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    do_reset();
    // main function, two different patterns, no underflow
    load(128'h8001_7FFE_A5A5_0F0F_1234_5678_9ABC_DEF0);
    pulse(1);
    wait_n(20);
    load(128'hFFFF_0000_C3C3_3C3C_0001_8000_5555_AAAA);
    wait_n(PER);
    pulse(1);
    wait_n(PER);
    chk("R7 no underflow with frames supplied", FW'(underflow), '0);
    chk("R5 sclk rises", FW'(rises), FW'(2 * FB));
    chk("R3 sclk idle", FW'(sclk), '0);
    chk("R5 sdata idle", FW'(sdata), '0);
    chk("R2 latch rises", FW'(latch_rises), FW'(2));
    // R7: tick without a frame repeats the previous one
    pulse(1);
    wait_n(PER);
    chk("R7 underflow set", FW'(underflow), FW'(1));
    chk("R5 repeat rises", FW'(rises), FW'(3 * FB));
    load(128'h0F0F_F0F0_1111_2222_3333_4444_5555_6666);
    pulse(1);
    wait_n(PER);
    chk("R9 underflow kept", FW'(underflow), FW'(1));

    // R8: tick during shift is dropped, buffered frame kept
    do_reset();
    load(128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98);
    pulse(1);
    wait_n(20);
    load(128'h7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE);
    wait_n(30);
    pulse(1);
    wait_n(2);
    chk("R8 underflow on busy tick", FW'(underflow), FW'(1));
    chk("R8 frame not consumed", FW'(ld_ready), '0);
    wait_n(PER);
    chk("R8 one latch pulse", FW'(latch_rises), FW'(1));
    pulse(1);
    wait_n(PER);
    chk("R8 kept frame shifted", FW'(rises), FW'(2 * FB));

    // R8: tick held into the latch cycle
    do_reset();
    load(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10);
    pulse(2);
    wait_n(PER);
    chk("R8 latch-cycle tick dropped", FW'(latch_rises), FW'(1));
    chk("R8 latch-cycle underflow", FW'(underflow), FW'(1));

    // R7: load and tick in the same cycle with empty buffer
    do_reset();
    @(negedge clk); tick = 1; ld_valid = 1;
    ld_data = 128'hCAFE_F00D_1357_2468_ACE0_BDF1_0000_FFFF;
    @(negedge clk); tick = 0; ld_valid = 0;
    wait_n(2);
    chk("R7 same-cycle underflow", FW'(underflow), FW'(1));
    chk("R7 same-cycle frame buffered", FW'(ld_ready), '0);
    wait_n(PER);
    pulse(1);
    wait_n(PER);
    chk("R6 ready after take", FW'(ld_ready), FW'(1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule